// File: doc/BRIEF.md
# Line-granular memory copy engine

The engine copies a contiguous block of physical memory from a source range to a destination range. Software, or a host-side sequencer, presents a start command with a source base, a destination base and a byte length. The engine cuts the block into 64-byte lines. For each line it sends a read request to the coherence directory, waits for the returned line, then sends a write of that same data to the matching destination line. Coherence actions such as downgrading or invalidating other holders belong to the directory, so the engine never talks to other caches.

There is no data array. Each line in flight occupies one of a small pool of tracking entries. An entry is claimed when the source read is accepted, holds the line's data from the read response until its write is acknowledged, and is then released. The directory may hold off any request by keeping its ready low. A stalled write keeps its entry and its request unchanged until it is accepted. Writes leave in the order their read data came back, whatever order the reads were issued in.

Top module: `dce_copy_engine`

## Requirements
- R1: An idle engine takes a command whose length is non-zero and has its low six bits clear, and `busy` is high from the next cycle. A zero length or one with any of the low six bits set gives a one-cycle `err` pulse on the next cycle instead, with `busy` staying low and no request issued.
- R2: A command presented while `busy` is high is ignored: the addresses of the transfer in progress and its single completion are unchanged.
- R3: Reads (`req_write` = 0) are issued in ascending order at source base + 64·k for k = 0 to lines−1, and `req_tag` names the entry that owns the line.
- R4: Each write (`req_write` = 1) carries exactly the line data returned for its read, at destination base plus that line's offset from the source base, with the owning entry's tag.
- R5: At most ENTRIES (default 4) lines are in flight, counted from read acceptance to write acknowledgement. A read is issued only when an entry is free, and a read never uses a tag that is still in flight.
- R6: Writes are issued in the order in which read responses (`rsp_is_ack` = 0) arrived, and reads may return in any order.
- R7: While any returned line is waiting to be written, the request port offers a write and not a read.
- R8: A write not accepted because `req_ready` is low stays on the port with the same valid, address, data and tag until it is accepted.
- R9: `done` pulses for one cycle, the cycle after the acknowledgement (`rsp_is_ack` = 1) of the last line, and `busy` falls in that same cycle. `req_valid` is low whenever `busy` is low.
- R10: During and after reset, `busy`, `done`, `err` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start command present |
| cmd_src | input | ADDR_W | Source base address |
| cmd_dst | input | ADDR_W | Destination base address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejected-command pulse |
| req_valid | output | 1 | Request to the directory present |
| req_ready | input | 1 | Directory accepts the request this cycle |
| req_write | output | 1 | 1 = line write, 0 = line read |
| req_addr | output | ADDR_W | Line address of the request |
| req_wdata | output | 512 | Line data for writes, zero for reads |
| req_tag | output | TAG_W | Entry that owns the request |
| rsp_valid | input | 1 | Response from the directory present |
| rsp_is_ack | input | 1 | 1 = write acknowledgement, 0 = read data |
| rsp_tag | input | TAG_W | Entry the response belongs to |
| rsp_rdata | input | 512 | Returned line data for reads |

## Verification
Two functions can fall in the same cycle: a read response pushing its entry onto the write-order queue, and the head write of that queue being accepted and popped. The bench provokes the overlap with random response latencies, which also return reads out of order, and with random stalls on `req_ready`. A behavioural model keeps the arrival order in a queue and compares the address, data and tag of every accepted write against the queue head. A second overlap, an acknowledgement freeing an entry while the pool is full, is judged by tracking in-flight tags and their count on every read acceptance.

// File: rtl/dce_pkg.sv
package dce_pkg;
    localparam int LINE_BYTES = 64;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int OFS_BITS   = $clog2(LINE_BYTES);

    // Life cycle of one tracking entry
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,  // unused
        ENT_RD   = 2'd1,  // source read accepted, data not back yet
        ENT_HOLD = 2'd2,  // data held, write not yet accepted
        ENT_WR   = 2'd3   // write accepted, waiting for acknowledgement
    } ent_state_e;
endpackage

// File: rtl/dce_tag_fifo.sv
module dce_tag_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_tag,
    input  logic         pop,
    output logic [W-1:0] head_tag,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.slot[f_q.wr] = push_tag;
            f_d.wr = (f_q.wr == PW'(DEPTH - 1)) ? '0 : f_q.wr + 1'b1;
        end
        if (pop) begin
            f_d.rd = (f_q.rd == PW'(DEPTH - 1)) ? '0 : f_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_tag = f_q.slot[f_q.rd];
    assign empty    = (f_q.cnt == '0);
endmodule

// File: rtl/dce_entry_pool.sv
module dce_entry_pool
    import dce_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 512,
    parameter int TAG_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_dst,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              send_en,
    input  logic [TAG_W-1:0]  send_tag,
    input  logic              ack_en,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [DATA_W-1:0] rd_data,
    output logic              free_any,
    output logic [TAG_W-1:0]  free_idx
);
    typedef struct packed {
        ent_state_e [ENTRIES-1:0]              st;
        logic       [ENTRIES-1:0][ADDR_W-1:0]  dst;
        logic       [ENTRIES-1:0][DATA_W-1:0]  data;
    } pool_t;

    pool_t p_d, p_q;

    // Lowest free entry, from registered state only
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (p_q.st[i] == ENT_FREE) begin
                free_any = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end

    always_comb begin
        p_d = p_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (alloc_en && free_any && (free_idx == TAG_W'(i))) begin
                p_d.st[i]  = ENT_RD;
                p_d.dst[i] = alloc_dst;
            end
            if (fill_en && (fill_tag == TAG_W'(i)) && (p_q.st[i] == ENT_RD)) begin
                p_d.st[i]   = ENT_HOLD;
                p_d.data[i] = fill_data;
            end
            if (send_en && (send_tag == TAG_W'(i)) && (p_q.st[i] == ENT_HOLD)) begin
                p_d.st[i] = ENT_WR;
            end
            if (ack_en && (ack_tag == TAG_W'(i)) && (p_q.st[i] == ENT_WR)) begin
                p_d.st[i] = ENT_FREE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rd_dst  = p_q.dst[rd_tag];
    assign rd_data = p_q.data[rd_tag];
endmodule

// File: rtl/dce_cmd_seq.sv
module dce_cmd_seq
    import dce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              rd_fire,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              rd_pending,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    localparam int CNT_W = LEN_W - OFS_BITS;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              err;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  rd_left;
        logic [CNT_W-1:0]  wr_left;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] n_lines;
    logic             len_ok;

    assign n_lines = cmd_len[LEN_W-1:OFS_BITS];
    assign len_ok  = (cmd_len[OFS_BITS-1:0] == '0) && (n_lines != '0);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (!s_q.busy) begin
            if (cmd_valid) begin
                if (len_ok) begin
                    s_d.busy    = 1'b1;
                    s_d.src     = cmd_src;
                    s_d.dst     = cmd_dst;
                    s_d.rd_left = n_lines;
                    s_d.wr_left = n_lines;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end else begin
            if (rd_fire) begin
                s_d.src     = s_q.src + ADDR_W'(LINE_BYTES);
                s_d.dst     = s_q.dst + ADDR_W'(LINE_BYTES);
                s_d.rd_left = s_q.rd_left - 1'b1;
            end
            if (wr_ack) begin
                s_d.wr_left = s_q.wr_left - 1'b1;
                if (s_q.wr_left == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign err        = s_q.err;
    assign rd_pending = (s_q.rd_left != '0);
    assign src_addr   = s_q.src;
    assign dst_addr   = s_q.dst;
endmodule

// File: rtl/dce_copy_engine.sv
module dce_copy_engine
    import dce_pkg::*;
#(
    parameter  int ADDR_W  = 32,
    parameter  int LEN_W   = 24,
    parameter  int ENTRIES = 4,
    localparam int TAG_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int LINE_W  = LINE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_src,
    input  logic [ADDR_W-1:0] cmd_dst,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LINE_W-1:0] req_wdata,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              rsp_valid,
    input  logic              rsp_is_ack,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [LINE_W-1:0] rsp_rdata
);
    logic              rd_pending, free_any, fifo_empty;
    logic              wr_want, rd_want, rd_fire, wr_fire, fill_en, ack_en;
    logic [ADDR_W-1:0] src_addr, dst_addr, wr_dst;
    logic [LINE_W-1:0] wr_data;
    logic [TAG_W-1:0]  free_idx, head_tag;

    // Writes win the port; a read needs a free entry
    assign wr_want = !fifo_empty;
    assign rd_want = busy && rd_pending && free_any;

    assign req_valid = wr_want || rd_want;
    assign req_write = wr_want;
    assign req_addr  = wr_want ? wr_dst  : src_addr;
    assign req_wdata = wr_want ? wr_data : '0;
    assign req_tag   = wr_want ? head_tag : free_idx;

    assign rd_fire = req_valid && req_ready && !req_write;
    assign wr_fire = req_valid && req_ready && req_write;
    assign fill_en = rsp_valid && !rsp_is_ack;
    assign ack_en  = rsp_valid && rsp_is_ack;

    dce_cmd_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_src    (cmd_src),
        .cmd_dst    (cmd_dst),
        .cmd_len    (cmd_len),
        .rd_fire    (rd_fire),
        .wr_ack     (ack_en),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .rd_pending (rd_pending),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr)
    );

    dce_entry_pool #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .DATA_W  (LINE_W),
        .TAG_W   (TAG_W)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (rd_fire),
        .alloc_dst (dst_addr),
        .fill_en   (fill_en),
        .fill_tag  (rsp_tag),
        .fill_data (rsp_rdata),
        .send_en   (wr_fire),
        .send_tag  (head_tag),
        .ack_en    (ack_en),
        .ack_tag   (rsp_tag),
        .rd_tag    (head_tag),
        .rd_dst    (wr_dst),
        .rd_data   (wr_data),
        .free_any  (free_any),
        .free_idx  (free_idx)
    );

    // Arrival order of read data fixes the write order
    dce_tag_fifo #(.DEPTH(ENTRIES), .W(TAG_W)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fill_en),
        .push_tag (rsp_tag),
        .pop      (wr_fire),
        .head_tag (head_tag),
        .empty    (fifo_empty)
    );
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LINE_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              rsp_is_ack
);
    localparam int CW = $clog2(ENTRIES + 2) + 1;
    logic [CW-1:0] flight_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flight_q <= '0;
        end else begin
            case ({req_valid && req_ready && !req_write, rsp_valid && rsp_is_ack})
                2'b10:   flight_q <= flight_q + 1'b1;
                2'b01:   flight_q <= flight_q - 1'b1;
                default: flight_q <= flight_q;
            endcase
        end
    end

    // R5
    flight_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flight_q <= CW'(ENTRIES));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_ready) |=>
            (req_valid && req_write && $stable(req_addr) && $stable(req_wdata)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R1
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
endmodule

bind dce_copy_engine dce_checker #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES),
    .LINE_W  (LINE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_is_ack (rsp_is_ack)
);

// File: tb/tb_dce_copy_engine.sv
module tb_dce_copy_engine;
    localparam int AW = 32;
    localparam int LW = 24;
    localparam int NE = 4;
    localparam int TW = 2;
    localparam int DW = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          busy, done, err;
    logic          req_valid, req_write;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [TW-1:0] req_tag;
    logic          rsp_valid = 1'b0, rsp_is_ack = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [DW-1:0] rsp_rdata = '0;

    always #4 clk = ~clk;

    dce_copy_engine #(.ADDR_W(AW), .LEN_W(LW), .ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
        .busy(busy), .done(done), .err(err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_is_ack(rsp_is_ack), .rsp_tag(rsp_tag), .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        int            t;
        bit            ack;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } rsp_t;

    typedef struct {
        logic [TW-1:0] tag;
        logic [AW-1:0] src;
    } line_t;

    int checks = 0, errors = 0, cyc = 0, wd = 0;
    rsp_t  pend[$];
    line_t wq[$];
    logic [AW-1:0] tag_src [NE];
    bit    tag_live [NE];
    bit    exp_busy = 0, exp_done = 0, exp_err = 0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    int    n_lines = 0, rd_k = 0, acks = 0, inflight = 0, max_inflight = 0;
    int    done_seen = 0, good_cmds = 0;
    int    ready_pct = 100, lat_min = 1, lat_span = 1;
    bit    c_valid = 0;
    logic [AW-1:0] c_src = '0, c_dst = '0;
    logic [LW-1:0] c_len = '0;
    bit    st_valid = 0;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic [TW-1:0] st_tag;

    function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
        logic [DW-1:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = a * 32'h0100_0193 + i * 32'h1111;
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // One clock of stimulus and reference model
    task automatic step();
        bit exp_busy_n, exp_done_n, exp_err_n;
        @(negedge clk);
        cyc++;
        // a) outputs caused by the previous edge
        if (rst_n) begin
            chk(busy == exp_busy, "R1", "busy", busy, exp_busy);
            chk(done == exp_done, "R9", "done", done, exp_done);
            chk(err == exp_err, "R1", "err", err, exp_err);
            if (done) done_seen++;
            // R7 returned data must go out as a write first
            if (wq.size() > 0)
                chk(req_valid && req_write, "R7", "write offered while data held", {req_valid, req_write}, 2'b11);
            // R8 stalled write held
            if (st_valid) begin
                chk(req_valid && req_write, "R8", "stalled write still valid", {req_valid, req_write}, 2'b11);
                chk(req_addr == st_addr, "R8", "stalled write address", req_addr, st_addr);
                chk(req_wdata == st_data, "R8", "stalled write data", req_wdata, st_data);
                chk(req_tag == st_tag, "R8", "stalled write tag", req_tag, st_tag);
            end
            // R9 quiet while idle
            if (!exp_busy) chk(!req_valid, "R9", "no request while idle", req_valid, 0);
        end
        // b) drive inputs for the coming edge
        req_ready = (($urandom % 100) < ready_pct);
        rsp_valid = 1'b0;
        rsp_is_ack = 1'b0;
        for (int i = 0; i < pend.size(); i++) begin
            if (pend[i].t <= cyc) begin
                rsp_valid = 1'b1;
                rsp_is_ack = pend[i].ack;
                rsp_tag = pend[i].tag;
                rsp_rdata = pend[i].data;
                pend.delete(i);
                break;
            end
        end
        cmd_valid = c_valid;
        cmd_src = c_src;
        cmd_dst = c_dst;
        cmd_len = c_len;
        #1;
        // c) model the coming edge
        exp_busy_n = exp_busy;
        exp_done_n = 0;
        exp_err_n = 0;
        st_valid = 0;
        if (rst_n) begin
            if (cmd_valid && !exp_busy) begin
                if (cmd_len[5:0] == 0 && cmd_len != 0) begin
                    exp_busy_n = 1;
                    src_base = cmd_src;
                    dst_base = cmd_dst;
                    n_lines = int'(cmd_len >> 6);
                    rd_k = 0;
                    acks = 0;
                    good_cmds++;
                end else begin
                    exp_err_n = 1;
                end
            end
            if (req_valid && req_ready) begin
                if (req_write) begin
                    if (wq.size() == 0) begin
                        chk(0, "R6", "write with no returned line", req_addr, 0);
                    end else begin
                        line_t h = wq.pop_front();
                        logic [AW-1:0] ed = dst_base + (h.src - src_base);
                        chk(req_addr == ed, "R6", "write address in arrival order", req_addr, ed);
                        chk(req_wdata == pat(h.src), "R4", "write data", req_wdata, pat(h.src));
                        chk(req_tag == h.tag, "R4", "write tag", req_tag, h.tag);
                    end
                    pend.push_back('{cyc + lat_min + int'($urandom % lat_span), 1'b1, req_tag, '0});
                end else begin
                    logic [AW-1:0] ea = src_base + AW'(64 * rd_k);
                    chk(req_addr == ea, "R3", "read address", req_addr, ea);
                    chk(!tag_live[req_tag], "R5", "read tag not in flight", tag_live[req_tag], 0);
                    tag_live[req_tag] = 1;
                    tag_src[req_tag] = req_addr;
                    rd_k++;
                    inflight++;
                    if (inflight > max_inflight) max_inflight = inflight;
                    chk(inflight <= NE, "R5", "lines in flight", inflight, NE);
                    pend.push_back('{cyc + lat_min + int'($urandom % lat_span), 1'b0, req_tag, pat(req_addr)});
                end
            end
            if (req_valid && req_write && !req_ready) begin
                st_valid = 1;
                st_addr = req_addr;
                st_data = req_wdata;
                st_tag = req_tag;
            end
            if (rsp_valid) begin
                if (rsp_is_ack) begin
                    tag_live[rsp_tag] = 0;
                    inflight--;
                    acks++;
                    if (acks == n_lines) begin
                        exp_done_n = 1;
                        exp_busy_n = 0;
                    end
                end else begin
                    wq.push_back('{rsp_tag, tag_src[rsp_tag]});
                end
            end
        end
        exp_busy = exp_busy_n;
        exp_done = exp_done_n;
        exp_err = exp_err_n;
    endtask

    task automatic issue(logic [AW-1:0] s, logic [AW-1:0] d, logic [LW-1:0] l);
        c_valid = 1; c_src = s; c_dst = d; c_len = l;
        step();
        c_valid = 0;
    endtask

    task automatic drain();
        while (exp_busy || pend.size() > 0 || exp_done || exp_err) step();
        repeat (3) step();
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d cycles expected fewer than 150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) tag_live[i] = 0;
        repeat (3) step();
        // R10 values held in reset
        chk(!busy && !done && !err && !req_valid, "R10", "outputs in reset", {busy, done, err, req_valid}, 0);
        rst_n = 1'b1;
        step();
        chk(!busy && !done && !err && !req_valid, "R10", "outputs after reset", {busy, done, err, req_valid}, 0);

        // R1 rejected lengths: not a line multiple, and zero
        issue(32'h0001_0000, 32'h0008_0000, 24'd100);
        step();
        chk(!busy && !req_valid, "R1", "rejected command starts nothing", {busy, req_valid}, 0);
        drain();
        issue(32'h0001_0000, 32'h0008_0000, 24'd0);
        drain();

        // Plain copy, always ready, fixed latency
        ready_pct = 100; lat_min = 1; lat_span = 1;
        issue(32'h0001_0000, 32'h0008_0000, 24'd512);
        drain();

        // Out-of-order returns and stalls (R6, R8)
        ready_pct = 60; lat_min = 1; lat_span = 8;
        issue(32'h0002_0000, 32'h0009_0000, 24'd1024);
        drain();

        // Long latency fills the pool (R5)
        max_inflight = 0;
        ready_pct = 100; lat_min = 20; lat_span = 1;
        issue(32'h0003_0000, 32'h000A_0000, 24'd768);
        drain();
        chk(max_inflight == NE, "R5", "pool fully used", max_inflight, NE);

        // Single line
        ready_pct = 100; lat_min = 2; lat_span = 3;
        issue(32'h0004_0040, 32'h000B_0040, 24'd64);
        drain();

        // Commands while busy are ignored (R2)
        ready_pct = 80; lat_min = 3; lat_span = 6;
        issue(32'h0005_0000, 32'h000C_0000, 24'd1024);
        c_valid = 1; c_src = 32'h0070_0000; c_dst = 32'h0078_0000; c_len = 24'd128;
        repeat (6) step();
        c_valid = 0;
        chk(exp_busy && busy, "R2", "transfer continues under new commands", busy, 1);
        drain();

        // Heavy write stalls (R8)
        ready_pct = 30; lat_min = 1; lat_span = 3;
        issue(32'h0006_0000, 32'h000D_0000, 24'd640);
        drain();

        chk(done_seen == good_cmds, "R9", "one done per accepted command", done_seen, good_cmds);
        chk(done_seen == 6, "R2", "accepted command count", done_seen, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule